// File: doc/BRIEF.md
# Serial EEPROM Write Command Engine

This block is the slave side of a small serial EEPROM model that sits behind a four-wire serial peripheral bus. The model holds up to 512 bytes in an internal register array. It watches chip select, clock and data-in on a free-running system clock through two-stage synchronizers. It frames each command between a falling and a rising chip-select edge and takes in bits on rising serial-clock edges. Because it only looks at edges, the clock may idle low (mode 0) or high (mode 3).

Three commands are decoded:
- **Write-enable** sets an enable flag.
- **Status read** shifts the flag and a not-ready bit out on the data-out line.
- **Write** carries the ninth address bit inside its opcode. It loads up to a page of data bytes into a latch.

When chip select rises cleanly after at least one whole data byte, the latched bytes are committed to the array at the end of a busy period of fixed length. The enable flag then drops. A read port on the side lets the surrounding model look at array contents.

Top module: `eeprom_write_engine`

## Requirements
- R1: After reset the array reads all zero, the data-out enable is low, and a status read returns 0x00.
- R2: Opcode 0x06 sets the enable flag. Opcode 0x05 shifts out the status byte MSB first: bit 1 is the enable flag, bit 0 is not-ready, and the other bits are 0. Each bit is changed after a falling clock edge so that it is valid at the next rising edge. The byte repeats for as long as chip select stays low.
- R3: A write is the opcode 0000_A010 (A = address bit 8), then one address byte and then data bytes, all MSB first. The data lands in the array once the busy period ends.
- R4: A write opcode received while the enable flag is clear is ignored, and the array is unchanged.
- R5: After each data byte the low four address bits increment while the page bits hold. A seventeenth or later byte wraps to the start of the same page and overwrites the byte latched there. No other page is touched.
- R6: Programming starts only on the chip-select rise that ends a write. From then the not-ready bit reads 1 for exactly WRITE_CYCLES system clocks.
- R7: While not-ready is 1, only the status read is served. A write command is ignored and leaves the array unchanged.
- R8: When the busy period ends, the enable flag clears by itself.
- R9: If chip select rises before a complete data byte, or between bit boundaries, the write is dropped: the array is unchanged, not-ready stays 0 and the enable flag is kept.
- R10: Writes and status reads behave the same when the serial clock idles high (mode 3) as when it idles low (mode 0).
- R11: With a 9-bit address, opcode bit 3 selects the upper 256 bytes (opcode 0x0A writes address 0x100 plus the address byte).
- R12: The data-out enable stays low throughout write and write-enable commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| soData | output | 1 | Serial data out value |
| soDrive | output | 1 | High when soData should be driven; otherwise the line is released |
| peekAddr | input | ADDR_W | Array look-up address |
| peekData | output | 8 | Array byte at peekAddr |

## Verification
The bench sends more than a page of data so that the address wraps. A latch that carried the increment into the page bits would spill bytes into the next page; one that did not overwrite would keep the first value at the wrapped offset. It ends writes early, both inside a data byte and right after the address. A design that committed on any chip-select rise would then change memory or set not-ready. It also fires a second write into the busy window, which a design that checked only the enable flag would accept. Status is polled during and after the busy window, and the same traffic is repeated with a high-idling clock. This exposes a missing automatic clear of the enable flag and any edge handling that only works in one clock polarity.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef struct packed {
    logic clearLatch;
    logic loadAddr;
    logic storeData;
    logic loadStatus;
    logic commit;
    logic txEn;
  } eewrStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_DATA, ST_STAT, ST_SKIP
  } eewrState_e;
endpackage

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csFall,
  input  logic        csRise,
  input  logic        byteDone,
  input  logic [7:0]  rxByte,
  input  logic        atBoundary,
  output eewrStrobe_t strb,
  output logic        a8,
  output logic        busy,
  output logic        wel,
  output logic [7:0]  statusByte
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  eewrState_e state;
  logic [TW-1:0] tmr;
  logic gotData;
  logic isWrite;

  assign isWrite = (rxByte[7:4] == 4'h0) && (rxByte[2:0] == 3'b010) &&
                   ((ADDR_W == 9) || !rxByte[3]);
  assign statusByte = {6'b0, wel, busy};

  always_comb begin
    strb = '0;
    strb.txEn = (state == ST_STAT);
    strb.commit = busy && (tmr == '0);
    if (byteDone) begin
      case (state)
        ST_OP: begin
          if (rxByte == OP_RDSR) strb.loadStatus = 1'b1;
          else if (isWrite && wel && !busy) strb.clearLatch = 1'b1;
        end
        ST_STAT: strb.loadStatus = 1'b1;
        ST_ADDR: strb.loadAddr = 1'b1;
        ST_DATA: strb.storeData = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      gotData <= 1'b0;
      a8      <= 1'b0;
      busy    <= 1'b0;
      wel     <= 1'b0;
    end else begin
      if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
      if (csFall) begin
        state   <= ST_OP;
        gotData <= 1'b0;
      end else if (csRise) begin
        if (state == ST_DATA && gotData && atBoundary) begin
          busy <= 1'b1;
          tmr  <= TW'(WRITE_CYCLES - 1);
        end
        state <= ST_IDLE;
      end else if (byteDone) begin
        case (state)
          ST_OP: begin
            if (rxByte == OP_RDSR) begin
              state <= ST_STAT;
            end else if (rxByte == OP_WREN && !busy) begin
              wel   <= 1'b1;
              state <= ST_SKIP;
            end else if (isWrite && wel && !busy) begin
              a8    <= rxByte[3];
              state <= ST_ADDR;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR: state <= ST_DATA;
          ST_DATA: gotData <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eewr_dpath.sv
module eewr_dpath
  import eewr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  eewrStrobe_t       strb,
  input  logic              a8,
  input  logic [7:0]        statusByte,
  output logic              csFall,
  output logic              csRise,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              atBoundary,
  output logic              soData,
  output logic              soDrive,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [1:0] sckS, csS, siS;
  logic sckQ, csQ, sckRise, sckFall, csLow;
  logic [2:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic [PG_W-1:0] pageQ;
  logic [OFF_W-1:0] offQ;
  logic [PAGE_BYTES-1:0] valid;
  logic [7:0] latch [PAGE_BYTES];
  logic [7:0] mem [DEPTH];
  logic [8:0] fullAddr;
  logic [ADDR_W-1:0] startAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS <= 2'b00; csS <= 2'b11; siS <= 2'b00;
      sckQ <= 1'b0;  csQ <= 1'b1;
    end else begin
      sckS <= {sckS[0], sck};
      csS  <= {csS[0], csN};
      siS  <= {siS[0], si};
      sckQ <= sckS[1];
      csQ  <= csS[1];
    end
  end

  assign sckRise = sckS[1] & ~sckQ;
  assign sckFall = ~sckS[1] & sckQ;
  assign csLow   = ~csS[1];
  assign csFall  = ~csS[1] & csQ;
  assign csRise  = csS[1] & ~csQ;
  assign atBoundary = (bitCnt == 3'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; rxShift <= '0; rxByte <= '0; byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (csFall) begin
        bitCnt <= '0;
      end else if (sckRise && csLow) begin
        rxShift <= {rxShift[6:0], siS[1]};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == 3'd7) begin
          byteDone <= 1'b1;
          rxByte   <= {rxShift[6:0], siS[1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0; soData <= 1'b0;
    end else if (strb.loadStatus) begin
      txShift <= statusByte;
    end else if (sckFall && csLow) begin
      soData  <= txShift[7];
      txShift <= {txShift[6:0], 1'b0};
    end
  end
  assign soDrive = strb.txEn;

  assign fullAddr  = {a8, rxByte};
  assign startAddr = fullAddr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0; offQ <= '0; valid <= '0;
    end else begin
      if (strb.clearLatch) valid <= '0;
      if (strb.loadAddr) begin
        pageQ <= startAddr[ADDR_W-1:OFF_W];
        offQ  <= startAddr[OFF_W-1:0];
      end
      if (strb.storeData) begin
        valid[offQ] <= 1'b1;
        offQ <= offQ + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) latch[g] <= '0;
      else if (strb.storeData && offQ == OFF_W'(g)) latch[g] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (valid[i]) mem[{pageQ, OFF_W'(i)}] <= latch[i];
    end
  end

  assign peekData = mem[peekAddr];
endmodule

// File: rtl/eeprom_write_engine.sv
module eeprom_write_engine
  import eewr_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              soData,
  output logic              soDrive,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData
);
  eewrStrobe_t strb;
  logic csFall, csRise, byteDone, atBoundary, a8, busy, wel;
  logic [7:0] rxByte, statusByte;

  eewr_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .byteDone(byteDone), .rxByte(rxByte), .atBoundary(atBoundary),
    .strb(strb), .a8(a8), .busy(busy), .wel(wel), .statusByte(statusByte)
  );

  eewr_dpath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .strb(strb), .a8(a8), .statusByte(statusByte),
    .csFall(csFall), .csRise(csRise), .byteDone(byteDone), .rxByte(rxByte),
    .atBoundary(atBoundary), .soData(soData), .soDrive(soDrive),
    .peekAddr(peekAddr), .peekData(peekData)
  );
endmodule

// File: rtl/eewr_checker.sv
module eewr_checker
  import eewr_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        wel,
  input logic        csRise,
  input logic        soDrive,
  input eewrStrobe_t strb
);
  int busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  // R6
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));

  // R4
  wel_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  // R8
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R7
  busy_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.storeData && !strb.loadAddr);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == WRITE_CYCLES);

  // R2
  drive_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soDrive) |-> $past(strb.loadStatus));
endmodule

bind eeprom_write_engine eewr_checker #(.WRITE_CYCLES(WRITE_CYCLES)) chk (.*);

// File: tb/eeprom_write_engine_test.sv
module eeprom_write_engine_test;
  localparam int HP = 8;
  localparam int WC = 800;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic soData, soDrive;
  logic [8:0] peekAddr = '0;
  logic [7:0] peekData;

  eeprom_write_engine #(.ADDR_W(9), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .soData(soData), .soDrive(soDrive), .peekAddr(peekAddr), .peekData(peekData)
  );

  always #4 clk = ~clk;

  typedef struct { string req; int val; } item_t;
  item_t expQ[$];
  int actQ[$];
  int compared = 0, mismatched = 0;
  int mode = 0;
  logic inWrite = 1'b0, driveBad = 1'b0, done = 1'b0;
  logic [7:0] model [512];

  always @(negedge clk) if (inWrite && soDrive) driveBad <= 1'b1;

  // monitor: pops and compares
  always @(negedge clk) begin
    while (expQ.size() > 0 && actQ.size() > 0) begin
      item_t e;
      int a;
      e = expQ.pop_front();
      a = actQ.pop_front();
      compared++;
      if (a != e.val) begin
        mismatched++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", e.req, a, e.val);
      end
    end
  end

  task automatic expectVal(input string req, input int exp, input int act);
    expQ.push_back('{req, exp});
    actQ.push_back(act);
  endtask

  task automatic xferBits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck <= 1'b0; si <= b[i];
      repeat (HP) @(negedge clk);
      sck <= 1'b1; r[i] = soData;
      repeat (HP) @(negedge clk);
    end
    if (mode == 0) sck <= 1'b0;
  endtask

  task automatic xferByte(input logic [7:0] b);
    logic [7:0] r;
    xferBits(b, 8, r);
  endtask

  task automatic selLow();
    sck <= (mode == 3);
    @(negedge clk);
    csN <= 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic selHigh();
    repeat (HP) @(negedge clk);
    csN <= 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic readStatus(output logic [7:0] s);
    selLow();
    xferByte(8'h05);
    xferBits(8'h00, 8, s);
    selHigh();
  endtask

  task automatic checkStatus(input string req, input int exp);
    logic [7:0] s;
    readStatus(s);
    expectVal(req, exp, s);
  endtask

  task automatic writeEnable();
    inWrite = 1'b1;
    selLow(); xferByte(8'h06); selHigh();
    inWrite = 1'b0;
  endtask

  task automatic writeBytes(input logic [8:0] addr, input int n, input int base);
    inWrite = 1'b1;
    selLow();
    xferByte({4'h0, addr[8], 3'b010});
    xferByte(addr[7:0]);
    for (int k = 0; k < n; k++) xferByte(8'(base + k));
    selHigh();
    inWrite = 1'b0;
  endtask

  task automatic waitReady();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      readStatus(s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic checkPeek(input string req, input int addr);
    peekAddr <= 9'(addr);
    @(negedge clk); @(negedge clk);
    expectVal(req, model[addr], peekData);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN <= 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    expectVal("R1 drive", 0, soDrive);
    checkStatus("R1 status", 8'h00);
    checkPeek("R1 array", 0);

    // R4 write without enable ignored
    writeBytes(9'h010, 1, 8'hAA);
    checkStatus("R4 status", 8'h00);
    checkPeek("R4 array", 9'h010);

    // R2 enable then status, two repeats in one frame
    writeEnable();
    selLow(); xferByte(8'h05);
    xferBits(8'h00, 8, r); expectVal("R2 status first", 8'h02, r);
    xferBits(8'h00, 8, r); expectVal("R2 status repeat", 8'h02, r);
    selHigh();

    // R3 R6 R8 basic write
    writeBytes(9'h010, 2, 8'hAA);
    checkStatus("R6 busy status", 8'h03);
    waitReady();
    checkStatus("R8 enable cleared", 8'h00);
    model[9'h010] = 8'hAA; model[9'h011] = 8'hAB;
    checkPeek("R3 byte0", 9'h010);
    checkPeek("R3 byte1", 9'h011);

    // R5 wrap within page
    writeEnable();
    writeBytes(9'h02E, 18, 8'h40);
    waitReady();
    for (int k = 0; k < 18; k++) model[9'h020 + ((14 + k) % 16)] = 8'(8'h40 + k);
    for (int k = 0; k < 16; k++) checkPeek("R5 page", 9'h020 + k);
    checkPeek("R5 next page", 9'h030);

    // R11 upper half via opcode bit
    writeEnable();
    writeBytes(9'h105, 1, 8'h77);
    waitReady();
    model[9'h105] = 8'h77;
    checkPeek("R11 upper", 9'h105);
    checkPeek("R11 lower", 9'h005);

    // R9 abort inside data byte
    writeEnable();
    inWrite = 1'b1;
    selLow(); xferByte(8'h02); xferByte(8'h60); xferBits(8'h5A, 5, r); selHigh();
    inWrite = 1'b0;
    checkStatus("R9 mid-byte status", 8'h02);
    checkPeek("R9 mid-byte array", 9'h060);
    // R9 abort right after address
    inWrite = 1'b1;
    selLow(); xferByte(8'h02); xferByte(8'h61); selHigh();
    inWrite = 1'b0;
    checkStatus("R9 no-data status", 8'h02);
    // R9 abort off boundary after a full data byte
    inWrite = 1'b1;
    selLow(); xferByte(8'h02); xferByte(8'h62); xferByte(8'h33); xferBits(8'hFF, 3, r); selHigh();
    inWrite = 1'b0;
    checkStatus("R9 partial tail status", 8'h02);
    checkPeek("R9 partial tail array", 9'h062);

    // R10 R7 mode 3: write then write during busy
    mode = 3;
    sck <= 1'b1;
    repeat (HP) @(negedge clk);
    writeBytes(9'h040, 1, 8'h11);
    writeBytes(9'h050, 1, 8'h99);
    checkStatus("R10 mode3 busy status", 8'h03);
    waitReady();
    checkStatus("R7 status after", 8'h00);
    model[9'h040] = 8'h11;
    checkPeek("R10 mode3 write", 9'h040);
    checkPeek("R7 busy write ignored", 9'h050);

    // R12 data-out never driven during write traffic
    expectVal("R12 drive in write", 0, driveBad);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule